// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block lets a host microcontroller configure an audio converter over three wires: a mode line, a bus clock and a data line. The block samples all three lines with its own system clock and acts on rising edges of the bus clock. While the mode line is low, the host sends an address byte. The upper six bits of that byte name the device, and the lower two bits pick a target. While the mode line is high, the host sends data bytes to that target, or it clocks a 6-bit peak-level value out of the block.

Two configuration registers are held in the block. The status register carries the power, input-format and clock fields. The sound register carries the filter-mode and mute fields. Each received byte takes effect only when its eighth bit arrives. One address byte may be followed by any number of data bytes. The peak detector is outside this block and feeds it through an input port.

The controller is one state machine with four states. In `S_ADDR` it assembles the address byte. In `S_WR` it writes data bytes to the selected register. In `S_RD` it shifts out the captured peak value. In `S_SKIP` it ignores a data phase whose address did not match. The transitions are:
- `S_ADDR` goes to `S_WR`, `S_RD` or `S_SKIP` on a rising mode line, depending on the address match and the select code.
- Every other state returns to `S_ADDR` on a falling mode line.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset, `status_q` is 0x03 and `sound_q` is 0x00. So `adc_en`=1, `dac_en`=1, `fmt_sel`=0, `mute`=0 and `filt_mode`=0.
- R2: While `bus_mode` is low, bits are taken on rising edges of `bus_clk`, least significant bit first. Address bits [7:2] must equal the parameter `DEV_ADDR` (default 6'h05). Address bits [1:0] select the target: 00 is the sound register, 01 is peak read-out, 10 is the status register and 11 is no target.
- R3: A data byte is written to the selected register only on its eighth rising bus clock. If `bus_mode` falls before the eighth bit, the partial byte is discarded and no register changes.
- R4: Several bytes sent in one data phase are each committed in turn, so the register holds the last complete byte.
- R5: If the address does not match, or the select code is 11, the following data phase changes no register.
- R6: Status layout: [1:0] is power, [4:2] is input format (`fmt_sel`), [6:5] is clock rate and [7] is a reset flag. `adc_en` follows power bit 1 and `dac_en` follows power bit 0. Power code 00 turns off both converters.
- R7: Sound layout: [1:0] is filter mode and [2] is mute (1 means muted). `filt_mode` reports 0 (flat) for code 00, 1 (minimum) for codes 01 and 10, and 2 (maximum) for code 11.
- R8: In a read-out phase, `peak_level` is captured when `bus_mode` rises. `bus_dout` shows bit k of the captured value after k rising bus clocks, starting with bit 0. After six shifts it shows 0.
- R9: `bus_dout` is 0 outside a read-out phase. A read-out phase writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 1 | Low selects the address phase, high selects the data phase |
| bus_clk | input | 1 | Serial bus clock |
| bus_din | input | 1 | Serial data from the host |
| peak_level | input | 6 | Peak value from the detector |
| bus_dout | output | 1 | Serial read-out data to the host |
| status_q | output | 8 | Status register |
| sound_q | output | 8 | Sound register |
| adc_en | output | 1 | ADC powered |
| dac_en | output | 1 | DAC powered |
| fmt_sel | output | 3 | Input format code |
| mute | output | 1 | Mute active |
| filt_mode | output | 2 | Filter mode: 0 flat, 1 minimum, 2 maximum |

## Verification
A bus-clock edge or mode edge takes effect in the same system clock cycle in which it is first seen. A register write appears one system clock after the rising edge of the eighth bit, and `bus_dout` follows one system clock after each shift or capture. The bench changes inputs on falling system clock edges and holds every bus level for three system clocks. It samples outputs at the end of each hold, so every result has settled with at least one cycle of margin. The sweeps cover every status byte, every sound byte and every peak value.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    typedef enum logic [1:0] {
        S_ADDR = 2'd0,
        S_WR   = 2'd1,
        S_RD   = 2'd2,
        S_SKIP = 2'd3
    } ctl_state_e;

    localparam logic [1:0] SEL_SOUND  = 2'b00;
    localparam logic [1:0] SEL_PEAK   = 2'b01;
    localparam logic [1:0] SEL_STATUS = 2'b10;
    localparam logic [1:0] SEL_NONE   = 2'b11;

    localparam logic [7:0] STATUS_RST = 8'h03;
    localparam logic [7:0] SOUND_RST  = 8'h00;
endpackage

// File: rtl/ctl3w_edge.sv
module ctl3w_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              din,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              idle
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (shift_en) begin
            sh  <= {din, sh[BYTE_W-1:1]};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign byte_done = shift_en && (cnt == LAST);
    assign byte_val  = {din, sh[BYTE_W-1:1]};
    assign idle      = (cnt == '0);
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_status,
    input  logic       wr_sound,
    input  logic [7:0] wdata,
    output logic [7:0] status_q,
    output logic [7:0] sound_q,
    output logic       adc_en,
    output logic       dac_en,
    output logic [2:0] fmt_sel,
    output logic       mute,
    output logic [1:0] filt_mode
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            sound_q  <= SOUND_RST;
        end else begin
            if (wr_status) status_q <= wdata;
            if (wr_sound)  sound_q  <= wdata;
        end
    end

    always_comb begin
        adc_en  = status_q[1];
        dac_en  = status_q[0];
        fmt_sel = status_q[4:2];
        mute    = sound_q[2];
        unique case (sound_q[1:0])
            2'b00:        filt_mode = 2'd0;
            2'b11:        filt_mode = 2'd2;
            default:      filt_mode = 2'd1;
        endcase
    end

    assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_status, wr_sound}));
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
    import ctl3w_pkg::*;
#(
    parameter int          PEAK_W   = 6,
    parameter logic [5:0]  DEV_ADDR = 6'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              bus_clk,
    input  logic              bus_din,
    input  logic [PEAK_W-1:0] peak_level,
    output logic              bus_dout,
    output logic [7:0]        status_q,
    output logic [7:0]        sound_q,
    output logic              adc_en,
    output logic              dac_en,
    output logic [2:0]        fmt_sel,
    output logic              mute,
    output logic [1:0]        filt_mode
);
    localparam int BYTE_W = 8;

    ctl_state_e        state, nxt;
    logic              clk_rise, clk_fall_unused, mode_rise, mode_fall;
    logic              shift_en, byte_done, sh_idle;
    logic [BYTE_W-1:0] byte_val;
    logic              wr_status, wr_sound;
    logic              addr_ok;
    logic [1:0]        sel_q;
    logic [PEAK_W-1:0] rd_sh;

    ctl3w_edge u_clk_edge (
        .clk(clk), .rst_n(rst_n), .sig(bus_clk),
        .rise(clk_rise), .fall(clk_fall_unused)
    );
    ctl3w_edge u_mode_edge (
        .clk(clk), .rst_n(rst_n), .sig(bus_mode),
        .rise(mode_rise), .fall(mode_fall)
    );

    ctl3w_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(mode_rise | mode_fall),
        .shift_en(shift_en), .din(bus_din),
        .byte_done(byte_done), .byte_val(byte_val), .idle(sh_idle)
    );

    ctl3w_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_status(wr_status), .wr_sound(wr_sound),
        .wdata(byte_val), .status_q(status_q), .sound_q(sound_q),
        .adc_en(adc_en), .dac_en(dac_en), .fmt_sel(fmt_sel),
        .mute(mute), .filt_mode(filt_mode)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_ADDR;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_ADDR: if (mode_rise) begin
                if (!addr_ok || sel_q == SEL_NONE) nxt = S_SKIP;
                else if (sel_q == SEL_PEAK)        nxt = S_RD;
                else                               nxt = S_WR;
            end
            S_WR, S_RD, S_SKIP: if (mode_fall) nxt = S_ADDR;
            default: nxt = S_ADDR;
        endcase
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        wr_status = 1'b0;
        wr_sound  = 1'b0;
        bus_dout  = 1'b0;
        unique case (state)
            S_ADDR: shift_en = clk_rise && !bus_mode;
            S_WR: begin
                shift_en  = clk_rise && !mode_fall;
                wr_status = byte_done && (sel_q == SEL_STATUS);
                wr_sound  = byte_done && (sel_q == SEL_SOUND);
            end
            S_RD:   bus_dout = rd_sh[0];
            S_SKIP: ;
            default: ;
        endcase
    end

    // address decode and read-out shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_ok <= 1'b0;
            sel_q   <= SEL_NONE;
            rd_sh   <= '0;
        end else begin
            if (mode_fall) addr_ok <= 1'b0;
            else if (state == S_ADDR && byte_done) begin
                addr_ok <= (byte_val[7:2] == DEV_ADDR);
                sel_q   <= byte_val[1:0];
            end
            if (state == S_ADDR && nxt == S_RD) rd_sh <= peak_level;
            else if (state == S_RD && clk_rise) rd_sh <= rd_sh >> 1;
        end
    end

    assert_partial_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fall |=> sh_idle);
    assert_commit_only_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WR) |=> ($stable(status_q) && $stable(sound_q)));
    assert_quiet_outside_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RD) |-> !bus_dout);
    assert_read_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD && $past(state) == S_ADDR) |-> (bus_dout == $past(peak_level[0])));
    assert_return_to_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ADDR && mode_fall) |=> (state == S_ADDR));
endmodule

// File: tb/ctl3w_slave_tb.sv
module ctl3w_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0, bus_clk = 1'b0, bus_din = 1'b0;
    logic [5:0] peak_level = '0;
    logic       bus_dout;
    logic [7:0] status_q, sound_q;
    logic       adc_en, dac_en, mute;
    logic [2:0] fmt_sel;
    logic [1:0] filt_mode;

    int checks = 0;
    int fails  = 0;

    localparam logic [5:0] DEV = 6'h05;

    always #2.5 clk = ~clk;

    ctl3w_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .bus_clk(bus_clk),
        .bus_din(bus_din), .peak_level(peak_level), .bus_dout(bus_dout),
        .status_q(status_q), .sound_q(sound_q), .adc_en(adc_en), .dac_en(dac_en),
        .fmt_sel(fmt_sel), .mute(mute), .filt_mode(filt_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        bus_din = b; bus_clk = 1'b0; hold();
        bus_clk = 1'b1; hold();
        bus_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) pulse(v[i]);
    endtask

    task automatic open_phase(input logic [5:0] dev, input logic [1:0] sel);
        bus_mode = 1'b0; hold();
        send_bits({dev, sel}, 8);
        hold();
        bus_mode = 1'b1; hold();
    endtask

    task automatic close_phase();
        bus_mode = 1'b0; hold();
    endtask

    int filt_exp;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hold();
        // R1 reset defaults
        chk(status_q == 8'h03, "R1 status", status_q, 8'h03);
        chk(sound_q == 8'h00, "R1 sound", sound_q, 0);
        chk(adc_en && dac_en, "R1 power", {adc_en, dac_en}, 3);
        chk(!mute && filt_mode == 0 && fmt_sel == 0, "R1 fields", {mute, filt_mode, fmt_sel}, 0);

        // R2 R6 exhaustive status writes
        for (int v = 0; v < 256; v++) begin
            open_phase(DEV, 2'b10);
            send_bits(8'(v), 8);
            hold();
            chk(status_q == 8'(v), "R2 status write", status_q, v);
            chk(adc_en == v[1] && dac_en == v[0], "R6 power decode", {adc_en, dac_en}, v & 3);
            chk(fmt_sel == 3'(v >> 2), "R6 format", fmt_sel, (v >> 2) & 7);
            chk(bus_dout == 1'b0, "R9 dout idle", bus_dout, 0);
            close_phase();
        end

        // R7 exhaustive sound writes
        for (int v = 0; v < 256; v++) begin
            open_phase(DEV, 2'b00);
            send_bits(8'(v), 8);
            hold();
            filt_exp = ((v & 3) == 0) ? 0 : ((v & 3) == 3) ? 2 : 1;
            chk(sound_q == 8'(v), "R7 sound write", sound_q, v);
            chk(int'(filt_mode) == filt_exp, "R7 filter", filt_mode, filt_exp);
            chk(mute == v[2], "R7 mute", mute, (v >> 2) & 1);
            close_phase();
        end

        // R3 partial byte dropped
        open_phase(DEV, 2'b10);
        send_bits(8'h5A, 8);
        hold();
        chk(status_q == 8'h5A, "R3 full byte", status_q, 8'h5A);
        send_bits(8'hFF, 7);
        hold();
        chk(status_q == 8'h5A, "R3 seven bits no commit", status_q, 8'h5A);
        close_phase();
        chk(status_q == 8'h5A, "R3 partial dropped", status_q, 8'h5A);

        // R4 multibyte
        open_phase(DEV, 2'b00);
        send_bits(8'h11, 8); hold();
        chk(sound_q == 8'h11, "R4 first byte", sound_q, 8'h11);
        send_bits(8'h22, 8); hold();
        chk(sound_q == 8'h22, "R4 second byte", sound_q, 8'h22);
        send_bits(8'h37, 8); hold();
        chk(sound_q == 8'h37, "R4 third byte", sound_q, 8'h37);
        close_phase();

        // R5 mismatch and code 11
        for (int a = 0; a < 64; a++) begin
            if (6'(a) == DEV) continue;
            open_phase(6'(a), 2'b10);
            send_bits(8'hC0, 8); hold();
            chk(status_q == 8'h5A, "R5 mismatch status", status_q, 8'h5A);
            close_phase();
        end
        open_phase(DEV, 2'b11);
        send_bits(8'h00, 8); hold();
        chk(status_q == 8'h5A && sound_q == 8'h37, "R5 code 11", {status_q, sound_q}, 16'h5A37);
        close_phase();

        // R8 R9 read-out of every peak value
        for (int p = 0; p < 64; p++) begin
            peak_level = 6'(p);
            open_phase(DEV, 2'b01);
            peak_level = ~6'(p);
            chk(bus_dout == p[0], "R8 bit0", bus_dout, p & 1);
            for (int k = 1; k <= 7; k++) begin
                pulse(1'b1);
                hold();
                chk(bus_dout == ((k < 6) ? ((p >> k) & 1) : 0), "R8 shift", bus_dout,
                    (k < 6) ? ((p >> k) & 1) : 0);
            end
            chk(status_q == 8'h5A && sound_q == 8'h37, "R9 read no write",
                {status_q, sound_q}, 16'h5A37);
            close_phase();
            chk(bus_dout == 1'b0, "R9 dout after read", bus_dout, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule